// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer

This block is a countdown watchdog that sits in a byte-wide configuration register space. Software programs a configuration byte and a reload value of up to 16 bits, written as a high byte and a low byte. Writing the low byte copies the combined value into the down-counter. A nonzero value starts the countdown, and a zero value stops it. The counter steps down once per second, or once per minute through a divide-by-60 prescaler on the incoming one-second strobe. A configuration bit picks which.

When the count reaches zero, a sticky timeout status bit sets. If reset is enabled, a single-cycle system reset request is also issued. With reset disabled, software can exercise the timer without rebooting the system. After expiry the counter rests at zero until it is reloaded. A build parameter selects an 8-bit or a 16-bit counter. In the 8-bit build the high-byte register does not exist.

Top module: `sm_watchdog`

## Requirements
- R1: After reset, `timeout_flag` and `rst_req` are 0, and reads of the control (0x71), configuration (0x72), value-low (0x73) and value-high (0x74) addresses return 0x00. Any other address reads 0x00 at all times.
- R2: The configuration register at 0x72 stores and reads back all 8 written bits. Its bit 7 selects the time unit (1 = seconds, 0 = minutes), and its bit 6 enables the reset request.
- R3: A write to 0x73 loads the counter with {byte last written to 0x74, written byte}. A write to 0x74 alone neither starts nor reloads the counter. Both value registers read back what was written.
- R4: In seconds mode the counter decrements on every `sec_tick` pulse, so a reload value N expires on exactly the Nth tick after the load.
- R5: In minutes mode one decrement happens per 60 ticks. The prescaler restarts from zero on every reload.
- R6: At expiry, control bit 0 (read at 0x71) and `timeout_flag` go to 1 and stay there. The counter stays at zero, and no later pulse occurs until the counter is reloaded.
- R7: At expiry, `rst_req` is high for exactly one cycle if configuration bit 6 is 1. It stays low if that bit is 0.
- R8: A load of value zero stops the timer, so no expiry follows however many ticks arrive. A reload takes priority over a tick in the same cycle.
- R9: A write to 0x71 with data bit 0 = 0 clears the status bit, and a write with bit 0 = 1 leaves it unchanged. Writing 0x00 to 0x71 does not start the counter.
- R10: With an 8-bit counter the address 0x74 reads 0x00, and its written data has no effect on the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| rst_req | output | 1 | One-cycle system reset request at expiry |
| timeout_flag | output | 1 | Sticky timeout status |

## Verification
The bench checks the exact tick on which the timer expires in both time units. A counter that is off by one, or a prescaler that is not cleared on reload, would move the flag by a tick or by up to 59 ticks. It checks that a masked reset never pulses and that an enabled reset pulses for exactly one cycle, then never again while the count sits at zero. A wrapping counter would fire repeatedly. It also covers high-byte-only writes, which must not start the timer, zero loads that must stop it, and the status clear rule. An 8-bit instance shows that the missing high byte reads zero and does not leak into the reload value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h71;
  localparam logic [7:0] ADDR_CFG  = 8'h72;
  localparam logic [7:0] ADDR_VLO  = 8'h73;
  localparam logic [7:0] ADDR_VHI  = 8'h74;
  localparam int CFG_UNIT_SEC = 7;
  localparam int CFG_RST_EN   = 6;
  localparam int CTRL_STATUS  = 0;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             expire,
  output logic [7:0]       rdata,
  output logic [7:0]       cfg_q,
  output logic [CNT_W-1:0] load_val,
  output logic             load,
  output logic             status_q
);
  localparam int HI_W = CNT_W - 8;

  logic [7:0] cfg_nxt, lo_q, lo_nxt;
  logic       status_nxt;
  logic [7:0] hi_rd;
  logic       wr_ctrl, wr_cfg, wr_lo, wr_hi;

  assign wr_ctrl = we && (addr == ADDR_CTRL);
  assign wr_cfg  = we && (addr == ADDR_CFG);
  assign wr_lo   = we && (addr == ADDR_VLO);
  assign wr_hi   = we && (addr == ADDR_VHI);
  assign load    = wr_lo;

  always_comb begin
    cfg_nxt    = wr_cfg ? wdata : cfg_q;
    lo_nxt     = wr_lo ? wdata : lo_q;
    status_nxt = status_q;
    if (wr_ctrl && !wdata[CTRL_STATUS]) status_nxt = 1'b0;
    if (expire) status_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= 8'h00;
      lo_q     <= 8'h00;
      status_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_nxt;
      lo_q     <= lo_nxt;
      status_q <= status_nxt;
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hi_q, hi_nxt;
      assign hi_nxt = wr_hi ? wdata[HI_W-1:0] : hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_nxt;
      end
      assign hi_rd    = 8'(hi_q);
      assign load_val = {hi_q, wdata};
    end else begin : g_nohi
      logic unused_hi;
      assign unused_hi = wr_hi;
      assign hi_rd     = 8'h00;
      assign load_val  = wdata;
    end
  endgenerate

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = {7'b0, status_q};
      ADDR_CFG:  rdata = cfg_q;
      ADDR_VLO:  rdata = lo_q;
      ADDR_VHI:  rdata = hi_rd;
      default:   rdata = 8'h00;
    endcase
  end

  // R6: status is sticky until a clearing control write
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !(wr_ctrl && !wdata[CTRL_STATUS])) |=> status_q);
  // R9: a clearing control write without expiry leaves status low
  a_r9_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[CTRL_STATUS] && !expire) |=> !status_q);
  // R2: configuration takes the written byte
  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic unit_sec,
  input  logic clear,
  output logic step
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_nxt;
  logic          adv;

  assign adv  = tick && run;
  assign step = adv && (unit_sec || (pre_q == LAST));

  always_comb begin
    pre_nxt = pre_q;
    if (clear || unit_sec)  pre_nxt = '0;
    else if (adv)           pre_nxt = (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nxt;
  end

  // R5: prescaler stays inside its divide range
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
  // R5: a reload restarts the prescaler
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             rst_en,
  output logic             running,
  output logic             expire,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             rst_nxt;

  assign running = (cnt_q != '0);
  assign expire  = !load && step && (cnt_q == ONE);

  always_comb begin
    cnt_nxt = cnt_q;
    if (load)      cnt_nxt = load_val;
    else if (step) cnt_nxt = cnt_q - ONE;
    rst_nxt = expire && rst_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      rst_req <= rst_nxt;
    end
  end

  // R6: an expired counter rests at zero until reloaded
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));
  // R4: without a step or load the count does not move
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt_q));
  // R7: the reset request lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7: no request while reset is masked
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rst_en));
endmodule

// File: rtl/sm_watchdog.sv
module sm_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int TICKS_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sec_tick,
  output logic       rst_req,
  output logic       timeout_flag
);
  logic [7:0]       cfg;
  logic [CNT_W-1:0] load_val;
  logic             load, expire, running, step;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .expire(expire), .rdata(reg_rdata), .cfg_q(cfg), .load_val(load_val),
    .load(load), .status_q(timeout_flag)
  );

  wdt_prescale #(.DIV(TICKS_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .run(running),
    .unit_sec(cfg[CFG_UNIT_SEC]), .clear(load), .step(step)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .step(step),
    .rst_en(cfg[CFG_RST_EN]), .running(running), .expire(expire),
    .rst_req(rst_req)
  );
endmodule

// File: tb/sm_watchdog_test.sv
module sm_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic sec_tick = 1'b0;
  logic [7:0] reg_rdata, rdata8;
  logic rst_req, timeout_flag, rst8, flag8;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_watchdog #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .rst_req(rst_req), .timeout_flag(timeout_flag)
  );

  sm_watchdog #(.CNT_W(8)) uut8 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata8), .sec_tick(sec_tick),
    .rst_req(rst8), .timeout_flag(flag8)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  // reference model of the 16-bit instance
  int m_cnt = 0, m_pre = 0;
  bit m_status = 0, m_rst = 0;
  logic [7:0] m_cfg = 0, m_lo = 0, m_hi = 0;

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h71: return {7'b0, m_status};
      8'h72: return m_cfg;
      8'h73: return m_lo;
      8'h74: return m_hi;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input bit we, input logic [7:0] a,
                       input logic [7:0] d, input bit tk);
    bit load, run, usec, dec, ex;
    load = we && a == 8'h73;
    run  = m_cnt != 0;
    usec = m_cfg[7];
    dec  = tk && run && (usec || m_pre == 59);
    ex   = !load && dec && m_cnt == 1;
    if (load || usec) m_pre = 0;
    else if (tk && run) m_pre = (m_pre == 59) ? 0 : m_pre + 1;
    if (load) m_cnt = int'(m_hi) * 256 + int'(d);
    else if (dec) m_cnt = m_cnt - 1;
    m_rst = ex && m_cfg[6];
    if (we && a == 8'h71 && !d[0]) m_status = 0;
    if (ex) m_status = 1;
    if (we && a == 8'h72) m_cfg = d;
    if (we && a == 8'h73) m_lo = d;
    if (we && a == 8'h74) m_hi = d;
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                      input bit tk, input string tag);
    reg_we = we; reg_addr = a; reg_wdata = d; sec_tick = tk;
    @(posedge clk);
    model(we, a, d, tk);
    @(negedge clk);
    check(tag, "timeout_flag", 32'(timeout_flag), 32'(m_status));
    check(tag, "rst_req", 32'(rst_req), 32'(m_rst));
    check(tag, "reg_rdata", 32'(reg_rdata), 32'(exp_read(a)));
    reg_we = 0; sec_tick = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    step(1, a, d, 0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 8'h71, 8'h00, 1, tag);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "timeout_flag", 32'(timeout_flag), 0);
    check("R1", "rst_req", 32'(rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 8'h70; a <= 8'h75; a++) step(0, 8'(a), 8'h00, 0, "R1");

    // R10 narrow build: high byte absent
    wr(8'h74, 8'h01, "R10");
    check("R10", "uut8 read 0x74", 32'(rdata8), 0);
    wr(8'h72, 8'hC0, "R2");
    wr(8'h73, 8'h03, "R3");
    ticks(2, "R10");
    check("R10", "uut8 flag before expiry", 32'(flag8), 0);
    ticks(1, "R10");
    check("R10", "uut8 flag at 3rd tick", 32'(flag8), 1);
    check("R10", "uut8 rst_req at 3rd tick", 32'(rst8), 1);
    check("R3", "wide flag still low", 32'(timeout_flag), 0);
    wr(8'h74, 8'h00, "R3");
    wr(8'h73, 8'h00, "R8");
    ticks(300, "R8");
    check("R8", "no expiry after zero load", 32'(timeout_flag), 0);

    // R4/R7 seconds mode with reset masked, sparse ticks
    wr(8'h72, 8'h80, "R2");
    wr(8'h73, 8'h05, "R4");
    for (int i = 0; i < 4; i++) begin ticks(1, "R4"); step(0, 8'h73, 0, 0, "R4"); end
    check("R4", "flag after 4 ticks", 32'(timeout_flag), 0);
    ticks(1, "R4");
    check("R4", "flag at 5th tick", 32'(timeout_flag), 1);
    check("R7", "masked reset stays low", 32'(rst_req), 0);
    // R6 sticky status, no further pulses
    ticks(20, "R6");
    wr(8'h71, 8'h01, "R9");
    check("R9", "status kept by bit0=1", 32'(timeout_flag), 1);
    wr(8'h71, 8'h00, "R9");
    check("R9", "status cleared", 32'(timeout_flag), 0);
    ticks(10, "R9");

    // R7 enabled reset: exactly one pulse
    wr(8'h72, 8'hC0, "R7");
    wr(8'h73, 8'h03, "R7");
    ticks(3, "R7");
    check("R7", "pulse at expiry", 32'(rst_req), 1);
    step(0, 8'h71, 0, 1, "R7");
    check("R7", "pulse one cycle", 32'(rst_req), 0);
    ticks(70, "R6");
    wr(8'h71, 8'h00, "R9");

    // R3 high byte alone does not start; full load 0x102
    wr(8'h74, 8'h01, "R3");
    ticks(5, "R3");
    check("R3", "high write alone idle", 32'(timeout_flag), 0);
    wr(8'h73, 8'h02, "R3");
    ticks(257, "R3");
    check("R3", "flag before 258th tick", 32'(timeout_flag), 0);
    ticks(1, "R3");
    check("R3", "flag at 258th tick", 32'(timeout_flag), 1);
    wr(8'h71, 8'h00, "R9");
    wr(8'h74, 8'h00, "R3");

    // R5 minutes mode, prescaler cleared by reload
    wr(8'h72, 8'h40, "R5");
    wr(8'h73, 8'h01, "R5");
    ticks(30, "R5");
    wr(8'h73, 8'h01, "R5");
    ticks(59, "R5");
    check("R5", "flag before 60 ticks", 32'(timeout_flag), 0);
    ticks(1, "R5");
    check("R5", "flag at 60th tick", 32'(timeout_flag), 1);
    check("R5", "reset pulse", 32'(rst_req), 1);
    wr(8'h71, 8'h00, "R9");

    // R8 load priority over a tick, then stop with zero
    wr(8'h72, 8'h80, "R8");
    wr(8'h73, 8'h01, "R8");
    step(1, 8'h73, 8'h02, 1, "R8");
    check("R8", "tick with reload ignored", 32'(timeout_flag), 0);
    ticks(1, "R8");
    wr(8'h73, 8'h00, "R8");
    ticks(10, "R8");
    check("R8", "stopped by zero", 32'(timeout_flag), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit we, tk;
      logic [7:0] a, d;
      we = ($urandom % 16) == 0;
      tk = ($urandom % 2) == 0;
      a  = 8'h70 + 8'($urandom % 6);
      d  = 8'($urandom);
      if (a == 8'h73) d = 8'($urandom % 8);
      if (a == 8'h74) d = (($urandom % 8) == 0) ? 8'h01 : 8'h00;
      if (a == 8'h71 && ($urandom % 2) == 0) d[0] = 1'b1;
      step(we, a, d, tk, "R4 R5 R6 R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule